// File: doc/BRIEF.md
# Masked Lock-Bit Register Bank

This block keeps a small bank of soft lock registers. Each register carries four lock bits, and each bit guards one protected byte address of some peripheral. Software changes lock bits with one bus write. That write carries the new lock values and a per-bit write-enable mask together, so unmasked bits keep their state and no read-modify-write is needed.

Each register has a static protection-size input: byte, halfword or word. When the granule is wider than a byte, a lock value written to the lowest bit of a granule is copied to every bit of that granule. Only the lowest bit's enable decides whether that granule is updated. The block does not decode the protected peripheral space and does not block writes to it. It only holds the lock state and presents it as a flat output vector.

Top module: `lockbank_top`

## Requirements
- R1: On the clock edge where synchronous active-low reset `rst_n` is low, every lock bit clears to 0, and `lock_o` reads all zeros from the next sample onward.
- R2: Write data bits [3:0] are the new lock values for lock bits 0..3. Bits [7:4] are the write-enable mask, where bit 4+m qualifies lock bit m. Bits [31:8] are ignored.
- R3: Byte granule (size code 2'b00): lock bit m takes data bit m only when enable bit m is 1. Otherwise it keeps its value.
- R4: Halfword granule (2'b01): when enable 0 is 1, lock bits 0 and 1 both take data bit 0. When enable 2 is 1, lock bits 2 and 3 both take data bit 2. Enables 1 and 3 and data bits 1 and 3 have no effect.
- R5: Word granule (2'b10): when enable 0 is 1, all four lock bits take data bit 0. When enable 0 is 0, all four keep their values, whatever enables 1..3 hold.
- R6: Size code 2'b11 behaves exactly like the byte granule.
- R7: A write with `wr_en` high updates only the register selected by the 3-bit `addr`. The other seven registers are unchanged.
- R8: `rd_data` combinationally returns the selected register's lock bits in bits [3:0] and zeros in all other bits, including the mask positions [7:4].
- R9: `lock_o` holds register k's lock bit m at bit 4*k+m, and shows a write's effect after the clock edge that accepts the write.
- R10: With `wr_en` low, no lock bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Lock register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data: lock values [3:0], enable mask [7:4] |
| rd_data | output | 32 | Selected register lock bits in [3:0], zero elsewhere |
| size_cfg | input | 16 | Two-bit protection-size code per register, register k at [2k+1:2k] |
| lock_o | output | 32 | All lock bits, register k at [4k+3:4k] |

## Verification
Two situations are the hardest to reach from the ports. The first is a wide-granule write whose upper enables or upper data bits disagree with bit 0. The second is a write whose enable 0 is clear while the other enables are set. Both must leave locks untouched or copy only bit 0, and a uniform random write seldom separates these cases from plain byte behaviour. The stimulus therefore starts from preset nonzero lock patterns and forces those mismatched combinations under each size code. It then reshuffles the size map several times during random traffic, so each register sees every code, including 2'b11.

// File: rtl/lockbank_pkg.sv
// Package: shared constants and the protection-size type for the lock bank.
// Assumes four lock bits per register and an 8-bit lock+mask field in the bus word.
package lockbank_pkg;
    localparam int unsigned LOCKS_PER_REG = 4;
    localparam int unsigned SIZE_W        = 2;

    typedef enum logic [SIZE_W-1:0] {
        GRAN_BYTE = 2'b00,
        GRAN_HALF = 2'b01,
        GRAN_WORD = 2'b10,
        GRAN_RSVD = 2'b11
    } gran_e;
endpackage

// File: rtl/lockbank_merge.sv
// Module: computes the next value of one lock register from a masked write.
// Assumes the size code is static while a write is in flight; code 2'b11 acts as byte.
module lockbank_merge
    import lockbank_pkg::*;
(
    input  logic [LOCKS_PER_REG-1:0] cur_i,
    input  logic [LOCKS_PER_REG-1:0] val_i,
    input  logic [LOCKS_PER_REG-1:0] en_i,
    input  logic [SIZE_W-1:0]        size_i,
    output logic [LOCKS_PER_REG-1:0] nxt_o
);
    // Purpose: select granule-replicated values and enables, then merge under mask.
    always_comb begin
        logic [LOCKS_PER_REG-1:0] v;
        logic [LOCKS_PER_REG-1:0] e;
        unique case (gran_e'(size_i))
            GRAN_HALF: begin
                v = {val_i[2], val_i[2], val_i[0], val_i[0]};
                e = {en_i[2],  en_i[2],  en_i[0],  en_i[0]};
            end
            GRAN_WORD: begin
                v = {LOCKS_PER_REG{val_i[0]}};
                e = {LOCKS_PER_REG{en_i[0]}};
            end
            default: begin
                v = val_i;
                e = en_i;
            end
        endcase
        nxt_o = (cur_i & ~e) | (v & e);
    end
endmodule

// File: rtl/lockbank_reg.sv
// Module: one lock register with its write-merge logic and local assertions.
// Assumes synchronous active-low reset; wr_i is already address-qualified.
module lockbank_reg
    import lockbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [LOCKS_PER_REG-1:0] val_i,
    input  logic [LOCKS_PER_REG-1:0] en_i,
    input  logic [SIZE_W-1:0]        size_i,
    output logic [LOCKS_PER_REG-1:0] lock_q
);
    logic [LOCKS_PER_REG-1:0] nxt;

    lockbank_merge u_merge (
        .cur_i (lock_q),
        .val_i (val_i),
        .en_i  (en_i),
        .size_i(size_i),
        .nxt_o (nxt)
    );

    // Purpose: hold lock bits, clear on reset, load merged value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    lock_q <= '0;
        else if (wr_i) lock_q <= nxt;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> lock_q == '0);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(lock_q));
    assert_word_no_en0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && size_i == 2'b10 && !en_i[0]) |=> $stable(lock_q));
    assert_word_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && size_i == 2'b10 && en_i[0]) |=> (lock_q == {4{$past(val_i[0])}}));
    assert_half_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && size_i == 2'b01) |=> (lock_q[1] == lock_q[0] || $stable(lock_q[1:0])));
    assert_byte_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && size_i[1] == size_i[0] && !en_i[3]) |=> $stable(lock_q[3]));
endmodule

// File: rtl/lockbank_top.sv
// Module: bank of lock registers on a simple register bus with flat lock output.
// Assumes size_cfg is static configuration; reads are combinational.
module lockbank_top
    import lockbank_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              wr_en,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [DATA_W-1:0]                 rd_data,
    input  logic [NUM_REGS*SIZE_W-1:0]        size_cfg,
    output logic [NUM_REGS*LOCKS_PER_REG-1:0] lock_o
);
    localparam int unsigned VAL_LSB = 0;
    localparam int unsigned EN_LSB  = LOCKS_PER_REG;

    logic [LOCKS_PER_REG-1:0] regs [NUM_REGS];
    logic [NUM_REGS-1:0]      sel;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        // Purpose: decode the address into a one-hot write select.
        assign sel[k] = wr_en && (addr == ADDR_W'(k));

        lockbank_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_i  (sel[k]),
            .val_i (wr_data[VAL_LSB +: LOCKS_PER_REG]),
            .en_i  (wr_data[EN_LSB +: LOCKS_PER_REG]),
            .size_i(size_cfg[k*SIZE_W +: SIZE_W]),
            .lock_q(regs[k])
        );
        assign lock_o[k*LOCKS_PER_REG +: LOCKS_PER_REG] = regs[k];
    end

    // Purpose: return the selected register's lock bits, masks read as zero.
    always_comb begin
        rd_data = '0;
        rd_data[LOCKS_PER_REG-1:0] = regs[addr];
    end

    assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    assert_rd_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:LOCKS_PER_REG] == '0);
endmodule

// File: tb/lockbank_top_tb_top.sv
// Bench: directed corners then seeded random traffic, checked against a model.
module lockbank_top_tb_top;
    logic        clk = 0;
    logic        rst_n;
    logic [2:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [15:0] size_cfg;
    logic [31:0] lock_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [8];

    always #2 clk = ~clk;

    lockbank_top dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .size_cfg(size_cfg), .lock_o(lock_o));

    function automatic logic [3:0] exp_next(logic [3:0] cur, logic [1:0] sz, logic [7:0] d);
        logic [3:0] v = d[3:0];
        logic [3:0] e = d[7:4];
        if (sz == 2'b01) begin
            v = {v[2], v[2], v[0], v[0]};
            e = {e[2], e[2], e[0], e[0]};
        end else if (sz == 2'b10) begin
            v = {4{v[0]}};
            e = {4{e[0]}};
        end
        return (cur & ~e) | (v & e);
    endfunction

    function automatic logic [31:0] model_vec();
        logic [31:0] r;
        for (int k = 0; k < 8; k++) r[4*k +: 4] = model[k];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [2:0] a, logic [31:0] d, logic en);
        addr = a; wr_data = d; wr_en = en;
        @(posedge clk);
        #1;
        wr_en = 0;
        if (en) model[a] = exp_next(model[a], size_cfg[2*a +: 2], d[7:0]);
    endtask

    task automatic set_reg(logic [2:0] a, logic [3:0] v);
        logic [1:0] keep = size_cfg[2*a +: 2];
        size_cfg[2*a +: 2] = 2'b00;
        do_write(a, {24'h0, 4'hF, v}, 1);
        size_cfg[2*a +: 2] = keep;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; addr = 0; wr_data = '1; size_cfg = 16'h0;
        for (int k = 0; k < 8; k++) model[k] = 4'h0;
        @(posedge clk); @(posedge clk); #1;
        check("R1 reset lock_o", lock_o, 32'h0);
        rst_n = 1;
        // R3 byte granule: only enabled bits change
        set_reg(0, 4'b1010);
        do_write(0, 32'h0000_0035, 1);  // en=0011 val=0101
        check("R3 byte partial mask", lock_o, model_vec());
        check("R3 byte value", {28'h0, lock_o[3:0]}, 32'h9);
        // R2 upper data bits ignored
        do_write(0, 32'hFFFF_FF00, 1);
        check("R2 upper bits ignored", lock_o, model_vec());
        // R4 halfword: en1/en3 and val1/val3 ignored
        size_cfg[3:2] = 2'b01;
        set_reg(1, 4'b0110);
        do_write(1, 32'h0000_00AA, 1);  // en=1010 val=1010 -> no change
        check("R4 half odd enables ignored", {28'h0, lock_o[7:4]}, 32'h6);
        do_write(1, 32'h0000_0015, 1);  // en0 only, val0=1 -> low pair 11
        check("R4 half low pair", {28'h0, lock_o[7:4]}, 32'h7);
        do_write(1, 32'h0000_0040, 1);  // en2, val2=0 -> upper pair 00
        check("R4 half high pair", {28'h0, lock_o[7:4]}, 32'h3);
        // R5 word
        size_cfg[5:4] = 2'b10;
        set_reg(2, 4'b0101);
        do_write(2, 32'h0000_00EE, 1);  // en0=0
        check("R5 word en0 clear holds", {28'h0, lock_o[11:8]}, 32'h5);
        do_write(2, 32'h0000_001E, 1);  // en0=1 val0=0
        check("R5 word fill zero", {28'h0, lock_o[11:8]}, 32'h0);
        do_write(2, 32'h0000_0011, 1);
        check("R5 word fill one", {28'h0, lock_o[11:8]}, 32'hF);
        // R6 code 11 acts as byte
        size_cfg[7:6] = 2'b11;
        do_write(3, 32'h0000_0024, 1);  // en1 only, val1=0; en2 off
        do_write(3, 32'h0000_0042, 1);  // en2, val2=0 ; val1 ignored
        check("R6 reserved code as byte", lock_o, model_vec());
        do_write(3, 32'h0000_0082, 1);
        check("R6 reserved code bit3", {28'h0, lock_o[15:12]}, 32'h0);
        // R10 no write strobe
        do_write(4, 32'h0000_00FF, 0);
        check("R10 idle no change", lock_o, model_vec());
        // R8 read
        addr = 2; #1;
        check("R8 read mask zero", rd_data, 32'hF);
        // random traffic; R7, R9
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) size_cfg = $urandom;
            do_write(3'($urandom), $urandom, ($urandom % 4) != 0);
            check("R7 R9 random lock_o", lock_o, model_vec());
            addr = 3'($urandom); #1;
            check("R8 random read", rd_data, {28'h0, model[addr]});
        end
        rst_n = 0;
        @(posedge clk); #1;
        rst_n = 1;
        for (int k = 0; k < 8; k++) model[k] = 4'h0;
        check("R1 reset after traffic", lock_o, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule